// File: doc/BRIEF.md
# Framed Byte-Stream Link Receiver

This block sits behind the capture stage of a source-synchronous point-to-point link. The capture stage presents one byte per clock together with the sampled frame level. The block rebuilds 104-bit mesh packets from that stream. A packet opens only where frame goes from low to high. The header bytes that follow give the control mode, destination address, data size and direction. Then come four data bytes, or eight for a 64-bit write. When frame stays high after the last byte of a 64-bit write, the stream continues as a burst. Each further packet reuses the header with its address moved up by 8, and its data bytes follow at once.

Finished packets go to one of two output streams: writes, and everything else as reads. Each stream is valid/ready with a two-entry buffer. While valid is high and ready is low, the packet is held unchanged, and packets leave each stream in arrival order. The two streams stall independently of each other. Each stream also drives a wait level back to the far transmitter. Wait rises as soon as the stream could take only one more complete transaction. The transmitter may still finish the transaction it has in flight, plus one more.

Top module: `rxl_deframer`

## Requirements
- R1: A beat is taken as byte 0 only when frame is high on it and was low on the beat before. Frame held high after a completed 32-bit packet opens nothing, and the bytes on those beats produce no packet.
- R2: Header bytes 1 to 5 decode as follows. Byte 1 gives ctrlmode in bits 7:4 and dstaddr[31:28] in bits 3:0. Bytes 2, 3 and 4 give dstaddr[27:20], [19:12] and [11:4]. Byte 5 gives dstaddr[3:0] in bits 7:4, datamode in bits 3:2, write in bit 1 and access in bit 0.
- R3: Bytes 6 to 9 arrive most significant byte first. For a write they form the data field; for a read they form the srcaddr field and the data field is zero. Bytes 10 to 13 of a 64-bit write (datamode 11) form the srcaddr field. A write of 32 bits or less has srcaddr zero.
- R4: A packet is complete after byte 9, or after byte 13 when it is a write with datamode 11. A packet with the write bit set goes to the write stream; any other packet goes to the read stream.
- R5: Frame high on the beat after byte 13 makes that beat byte 6 of a new packet. The new packet carries the previous header with dstaddr increased by 8. This can repeat any number of times.
- R6: If frame falls before the last expected byte, the partial packet is dropped, and the block waits for the next frame rising edge.
- R7: An output packet has access at bit 0, write at bit 1, datamode at 3:2, ctrlmode at 7:4, dstaddr at 39:8, data at 71:40 and srcaddr at 103:72.
- R8: A packet transfers on a clock where valid and ready are both high. While valid is high and ready is low, valid stays high and the packet does not change. Each stream keeps arrival order, and a stall on one stream does not block the other.
- R9: A stream's wait output is high when its buffer holds two packets, or when it holds one and its ready is low. Otherwise it is low.
- R10: During and just after reset, both valid outputs and both wait outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock; one byte per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_frame | input | 1 | Sampled frame level from the link |
| lnk_byte | input | 8 | Sampled link byte |
| wr_valid | output | 1 | Write stream holds a packet |
| wr_ready | input | 1 | Write stream consumer accepts |
| wr_pkt | output | 104 | Write stream packet |
| rd_valid | output | 1 | Read stream holds a packet |
| rd_ready | input | 1 | Read stream consumer accepts |
| rd_pkt | output | 104 | Read stream packet |
| far_wr_wait | output | 1 | Write push-back to the far transmitter |
| far_rd_wait | output | 1 | Read push-back to the far transmitter |

## Verification
The buffer overflow assertion assumes the far transmitter honours the wait level. It may finish the transaction in flight and start at most one more, but never starts another while a stream's wait is high and that stream is full. The stimulus respects this in three ways. A stalled stream never receives more than two packets. Ready is changed only while the link is idle. Bursts are sent only while the consumers are ready. The hold assertion on the outputs needs no assumption about ready.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int PKT_W  = 104;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] IDX_FIRST      = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SHORT_END  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_LONG_END   = 4'd13;
  localparam logic [IDX_W-1:0] IDX_BURST_NEXT = 4'd7;

  localparam logic [1:0] DM_DOUBLE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BODY,
    ST_TAIL
  } rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] dst;
    logic [3:0]        ctrl;
    logic [1:0]        dm;
    logic              wr;
    logic              acc;
  } mesh_pkt_t;
endpackage

// File: rtl/rxl_assembler.sv
module rxl_assembler
  import rxl_pkg::*;
#(
  parameter int unsigned ADDR_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic [7:0]       byte_i,
  output logic             push_o,
  output logic             push_wr_o,
  output logic [PKT_W-1:0] pkt_o
);
  rx_state_e         st_q;
  logic              frame_q;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        ctrl_q;
  logic [WORD_W-1:0] dst_q, lo_q, hi_q;
  logic [1:0]        dm_q;
  logic              wr_q, acc_q;
  logic              push_q, push_wr_q;
  mesh_pkt_t         pkt_q;

  logic              is_long, rise, at_last;
  logic [IDX_W-1:0]  last_idx;
  logic [WORD_W-1:0] lo_nx, hi_nx;
  mesh_pkt_t         pkt_nx;

  always_comb begin
    is_long  = wr_q && (dm_q == DM_DOUBLE);
    last_idx = is_long ? IDX_LONG_END : IDX_SHORT_END;
    rise     = frame_i && !frame_q;
    at_last  = (st_q == ST_BODY) && frame_i && (idx_q == last_idx);
    lo_nx    = {lo_q[WORD_W-9:0], byte_i};
    hi_nx    = {hi_q[WORD_W-9:0], byte_i};
    pkt_nx.ctrl = ctrl_q;
    pkt_nx.dst  = dst_q;
    pkt_nx.dm   = dm_q;
    pkt_nx.wr   = wr_q;
    pkt_nx.acc  = acc_q;
    if (wr_q) begin
      pkt_nx.data = is_long ? lo_q : lo_nx;
      pkt_nx.src  = is_long ? hi_nx : '0;
    end else begin
      pkt_nx.data = '0;
      pkt_nx.src  = lo_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      frame_q   <= 1'b0;
      idx_q     <= '0;
      ctrl_q    <= '0;
      dst_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      dm_q      <= '0;
      wr_q      <= 1'b0;
      acc_q     <= 1'b0;
      push_q    <= 1'b0;
      push_wr_q <= 1'b0;
      pkt_q     <= '0;
    end else begin
      frame_q <= frame_i;
      push_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (rise) begin
            st_q  <= ST_BODY;
            idx_q <= IDX_FIRST;
          end
        end
        ST_BODY: begin
          if (!frame_i) begin
            st_q <= ST_IDLE;
          end else begin
            case (idx_q)
              4'd1: begin
                ctrl_q         <= byte_i[7:4];
                dst_q[31:28]   <= byte_i[3:0];
              end
              4'd2: dst_q[27:20] <= byte_i;
              4'd3: dst_q[19:12] <= byte_i;
              4'd4: dst_q[11:4]  <= byte_i;
              4'd5: begin
                dst_q[3:0] <= byte_i[7:4];
                dm_q       <= byte_i[3:2];
                wr_q       <= byte_i[1];
                acc_q      <= byte_i[0];
              end
              4'd6, 4'd7, 4'd8, 4'd9:     lo_q <= lo_nx;
              4'd10, 4'd11, 4'd12, 4'd13: hi_q <= hi_nx;
              default: ;
            endcase
            if (at_last) begin
              push_q    <= 1'b1;
              push_wr_q <= wr_q;
              pkt_q     <= pkt_nx;
              st_q      <= is_long ? ST_TAIL : ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (frame_i) begin
            dst_q <= dst_q + WORD_W'(ADDR_STEP);
            lo_q  <= lo_nx;
            idx_q <= IDX_BURST_NEXT;
            st_q  <= ST_BODY;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o    = push_q;
  assign push_wr_o = push_wr_q;
  assign pkt_o     = pkt_q;

  // R1
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && frame_i && !frame_q) |=> (st_q == ST_BODY && idx_q == IDX_FIRST));

  // R4
  push_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> $past(frame_i));

  // R6
  drop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BODY && !frame_i) |=> (!push_q && st_q == ST_IDLE));

  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL && frame_i) |=>
      (idx_q == IDX_BURST_NEXT && dst_q == $past(dst_q) + WORD_W'(ADDR_STEP)));
endmodule

// File: rtl/rxl_pkt_buf.sv
module rxl_pkt_buf #(
  parameter int DATA_W = 104,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wait_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop, full;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o && ready_i;
  assign data_o  = mem[rp_q];
  assign wait_o  = full || ((cnt_q >= CNT_W'(DEPTH - 1)) && valid_o && !ready_i);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && (!full || pop)) begin
        mem[wp_q] <= data_i;
        wp_q      <= bump(wp_q);
      end
      if (pop) rp_q <= bump(rp_q);
      if ((push_i && (!full || pop)) && !pop) cnt_q <= cnt_q + 1'b1;
      else if (!(push_i && (!full || pop)) && pop) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full && !pop));

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/rxl_deframer.sv
module rxl_deframer
  import rxl_pkg::*;
#(
  parameter int BUF_DEPTH = 2,
  parameter int ADDR_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lnk_frame,
  input  logic [7:0]       lnk_byte,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [PKT_W-1:0] wr_pkt,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PKT_W-1:0] rd_pkt,
  output logic             far_wr_wait,
  output logic             far_rd_wait
);
  localparam int NUM_CH = 2;
  localparam int CH_WR  = 0;
  localparam int CH_RD  = 1;

  logic             asm_push, asm_wr;
  logic [PKT_W-1:0] asm_pkt;
  logic [NUM_CH-1:0] push_ch, vld_ch, rdy_ch, wait_ch;
  logic [PKT_W-1:0] data_ch [NUM_CH];

  rxl_assembler #(.ADDR_STEP(ADDR_STEP)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_i   (lnk_frame),
    .byte_i    (lnk_byte),
    .push_o    (asm_push),
    .push_wr_o (asm_wr),
    .pkt_o     (asm_pkt)
  );

  assign push_ch[CH_WR] = asm_push && asm_wr;
  assign push_ch[CH_RD] = asm_push && !asm_wr;
  assign rdy_ch[CH_WR]  = wr_ready;
  assign rdy_ch[CH_RD]  = rd_ready;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rxl_pkt_buf #(.DATA_W(PKT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_ch[c]),
      .data_i  (asm_pkt),
      .valid_o (vld_ch[c]),
      .ready_i (rdy_ch[c]),
      .data_o  (data_ch[c]),
      .wait_o  (wait_ch[c])
    );
  end

  assign wr_valid    = vld_ch[CH_WR];
  assign rd_valid    = vld_ch[CH_RD];
  assign wr_pkt      = data_ch[CH_WR];
  assign rd_pkt      = data_ch[CH_RD];
  assign far_wr_wait = wait_ch[CH_WR];
  assign far_rd_wait = wait_ch[CH_RD];

  // R4
  route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ch[CH_WR]) |=> wr_valid);

  // R9
  stalled_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> far_wr_wait);

  // R10
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !rd_valid) |-> (!far_wr_wait && !far_rd_wait));
endmodule

// File: tb/tb_rxl_deframer.sv
module tb_rxl_deframer;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lnk_frame = 1'b0;
  logic [7:0]   lnk_byte = 8'h00;
  logic         wr_ready = 1'b0, rd_ready = 1'b0;
  logic         wr_valid, rd_valid, far_wr_wait, far_rd_wait;
  logic [103:0] wr_pkt, rd_pkt;

  int errs = 0;
  int checks = 0;
  logic [103:0] exp_wr[$];
  logic [103:0] exp_rd[$];
  logic [103:0] e_w, e_r, prev_w, prev_r;
  logic         hold_w = 1'b0, hold_r = 1'b0;

  rxl_deframer dut (
    .clk(clk), .rst_n(rst_n), .lnk_frame(lnk_frame), .lnk_byte(lnk_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_pkt(wr_pkt),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_pkt(rd_pkt),
    .far_wr_wait(far_wr_wait), .far_rd_wait(far_rd_wait)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [103:0] mk(input logic [3:0] ctrl, input logic [31:0] dst,
      input logic [1:0] dm, input bit wr, input bit acc, input logic [31:0] lo, input logic [31:0] hi);
    logic [31:0] d, s;
    if (wr) begin
      d = lo;
      s = (dm == 2'b11) ? hi : 32'h0;
    end else begin
      d = 32'h0;
      s = lo;
    end
    return {s, d, dst, ctrl, dm, wr, acc};
  endfunction

  task automatic beat(input bit f, input logic [7:0] b);
    lnk_frame = f;
    lnk_byte  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 8'hA5);
  endtask

  task automatic word(input logic [31:0] w);
    beat(1'b1, w[31:24]); beat(1'b1, w[23:16]); beat(1'b1, w[15:8]); beat(1'b1, w[7:0]);
  endtask

  task automatic send(input logic [3:0] ctrl, input logic [31:0] dst, input logic [1:0] dm,
      input bit wr, input bit acc, input logic [31:0] lo, input logic [31:0] hi,
      input int nburst, input bit stay_high);
    logic [31:0] d = dst;
    logic [31:0] l = lo;
    logic [31:0] h = hi;
    beat(1'b0, 8'hFF);
    beat(1'b1, 8'h00);
    beat(1'b1, {ctrl, d[31:28]});
    beat(1'b1, d[27:20]);
    beat(1'b1, d[19:12]);
    beat(1'b1, d[11:4]);
    beat(1'b1, {d[3:0], dm, wr, acc});
    for (int k = 0; k <= nburst; k++) begin
      if (k > 0) begin
        d = d + 32'd8;
        l = l ^ (32'h01010101 * k);
        h = h + 32'(k);
      end
      word(l);
      if (wr && dm == 2'b11) word(h);
      if (wr) exp_wr.push_back(mk(ctrl, d, dm, wr, acc, l, h));
      else    exp_rd.push_back(mk(ctrl, d, dm, wr, acc, l, h));
    end
    if (!stay_high) beat(1'b0, 8'h00);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_w) chk(wr_valid && wr_pkt == prev_w, "R8 write held under stall", wr_pkt, prev_w);
      if (hold_r) chk(rd_valid && rd_pkt == prev_r, "R8 read held under stall", rd_pkt, prev_r);
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) chk(1'b0, "R4 unexpected write packet", wr_pkt, '0);
        else begin
          e_w = exp_wr.pop_front();
          chk(wr_pkt == e_w, "R7 write packet fields", wr_pkt, e_w);
        end
      end
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R4 unexpected read packet", rd_pkt, '0);
        else begin
          e_r = exp_rd.pop_front();
          chk(rd_pkt == e_r, "R7 read packet fields", rd_pkt, e_r);
        end
      end
      hold_w = wr_valid && !wr_ready;
      hold_r = rd_valid && !rd_ready;
      prev_w = wr_pkt;
      prev_r = rd_pkt;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 during reset
    chk({wr_valid, rd_valid, far_wr_wait, far_rd_wait} == 4'b0, "R10 reset outputs",
        {wr_valid, rd_valid, far_wr_wait, far_rd_wait}, 0);
    rst_n = 1'b1;
    idle(2);
    chk({wr_valid, rd_valid, far_wr_wait, far_rd_wait} == 4'b0, "R10 after reset",
        {wr_valid, rd_valid, far_wr_wait, far_rd_wait}, 0);
    wr_ready = 1'b1;
    rd_ready = 1'b1;

    // R2 R3 R4: 32-bit write, read, 64-bit write
    send(4'h3, 32'h8100_1234, 2'b10, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0, 0, 1'b0);
    send(4'hC, 32'h0ABC_DEF4, 2'b10, 1'b0, 1'b1, 32'h8100_0040, 32'h0, 0, 1'b0);
    send(4'h5, 32'h1234_5678, 2'b11, 1'b1, 1'b1, 32'h0102_0304, 32'hA0B0_C0D0, 0, 1'b0);
    // byte and half-word writes still end after byte 9
    send(4'h0, 32'hFFFF_FFF1, 2'b00, 1'b1, 1'b1, 32'h0000_007E, 32'h0, 0, 1'b0);
    send(4'h9, 32'h2000_0002, 2'b01, 1'b1, 1'b0, 32'h0000_BEEF, 32'h0, 0, 1'b0);
    idle(6);
    chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R4 single packets delivered",
        exp_wr.size() + exp_rd.size(), 0);

    // R5: burst with three continuations
    send(4'h7, 32'h4000_0FF8, 2'b11, 1'b1, 1'b1, 32'h1111_2222, 32'h3333_4444, 3, 1'b0);
    idle(6);
    chk(exp_wr.size() == 0, "R5 burst packets delivered", exp_wr.size(), 0);

    // R1: frame held high after a 32-bit packet opens nothing
    send(4'h1, 32'h0000_0100, 2'b10, 1'b1, 1'b1, 32'hCAFE_F00D, 32'h0, 0, 1'b1);
    for (int i = 0; i < 12; i++) beat(1'b1, 8'(8'h30 + i));
    idle(6);
    chk(exp_wr.size() == 0 && !wr_valid && !rd_valid, "R1 no packet without rising edge",
        {wr_valid, rd_valid}, 0);

    // R6: early frame fall drops the partial packet, next packet is clean
    beat(1'b1, 8'h00);
    beat(1'b1, 8'h12); beat(1'b1, 8'h34); beat(1'b1, 8'h56); beat(1'b1, 8'h78);
    beat(1'b1, 8'h9B); beat(1'b1, 8'hAA);
    idle(3);
    send(4'h2, 32'h0000_0008, 2'b10, 1'b0, 1'b1, 32'h7777_0000, 32'h0, 0, 1'b0);
    idle(6);
    chk(exp_rd.size() == 0 && !wr_valid, "R6 partial packet dropped", exp_rd.size(), 0);

    // R9 R8: stall the write stream
    wr_ready = 1'b0;
    send(4'h4, 32'h5000_0000, 2'b10, 1'b1, 1'b1, 32'hAAAA_0001, 32'h0, 0, 1'b0);
    idle(6);
    chk(far_wr_wait == 1'b1, "R9 wait with one entry stalled", far_wr_wait, 1);
    chk(far_rd_wait == 1'b0, "R9 read wait stays low", far_rd_wait, 0);
    send(4'h4, 32'h5000_0004, 2'b10, 1'b1, 1'b1, 32'hAAAA_0002, 32'h0, 0, 1'b0);
    idle(6);
    chk(far_wr_wait == 1'b1 && wr_valid, "R9 wait with buffer full", far_wr_wait, 1);
    wr_ready = 1'b1;
    idle(6);
    chk(far_wr_wait == 1'b0 && exp_wr.size() == 0, "R9 wait clears after drain", far_wr_wait, 0);

    // R8: read stall does not block writes
    rd_ready = 1'b0;
    send(4'hE, 32'h6000_0010, 2'b10, 1'b0, 1'b1, 32'h1357_9BDF, 32'h0, 0, 1'b0);
    send(4'h6, 32'h7000_0020, 2'b10, 1'b1, 1'b1, 32'h2468_ACE0, 32'h0, 0, 1'b0);
    idle(8);
    chk(exp_wr.size() == 0 && rd_valid, "R8 write passes stalled read", exp_wr.size(), 0);
    chk(far_rd_wait == 1'b1, "R9 read wait under stall", far_rd_wait, 1);
    rd_ready = 1'b1;
    idle(20);
    chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R4 all expected packets seen",
        exp_wr.size() + exp_rd.size(), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule